// File: doc/BRIEF.md
# SDR SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-rank x16 SDR SDRAM from reset until the device can take normal traffic. Out of reset it keeps the bus idle, with clock enable and both byte masks high, while a startup wait of at least 200 us counts down. After that it closes all banks with one precharge. It then loads the mode register with a 13-bit word supplied at its input and issues a burst of auto-refresh commands. At the end it raises a done flag that stays high until the next reset.

Every spacing is a nanosecond parameter. The block converts it to clock cycles from a clock-frequency parameter in kHz and always rounds up to a whole cycle, never using fewer than one cycle. Each command goes out at the earliest cycle its spacing allows. A memory controller holds off its own command path until the done flag is high and then takes over the pins.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and during every idle cycle of the sequence, the command lines {cs_n, ras_n, cas_n, we_n} show NOP = 4'b0111, with address and bank address at zero and init_done low.
- R2: The precharge appears exactly N_INIT cycles after the first rising clock edge that follows reset release. Here N_INIT = ceil(T_INIT_NS * CLK_FREQ_KHZ / 10^6), and T_INIT_NS defaults to 200000.
- R3: cke_o and every bit of dqm_o are high at all times, including during reset and after init_done.
- R4: The first command is a single precharge-all: the command lines show 4'b0010, address bit 10 is 1, every other address bit is 0, and the bank address is 0.
- R5: Exactly N_RP cycles after the precharge, a load-mode command (4'b0000) appears. Its address equals mode_i as sampled on the edge that issues it, and its bank address is 2'b00.
- R6: The first auto-refresh (4'b0001, address and bank address 0) follows the load-mode by exactly N_MRD cycles. In total, max(NUM_REFRESH, 8) refreshes are issued, spaced exactly N_RFC cycles apart. NUM_REFRESH defaults to 8.
- R7: Each spacing N_x equals ceil(T_x_NS * CLK_FREQ_KHZ / 10^6), with a minimum of 1, so a fractional cycle always counts as a full cycle.
- R8: init_done_o rises exactly N_RFC cycles after the last refresh. It then stays high until reset, and the command lines stay at NOP.
- R9: Asserting reset at any point, including mid-burst or after done, clears init_done_o and forces NOP at once. After release the whole sequence restarts from the startup wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | ROW_W (13) | Word placed on the address bus by the load-mode command |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W (13) | Address bus |
| ba_o | output | BANK_W (2) | Bank address |
| dqm_o | output | DQM_W (2) | Byte masks, held high |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds the block with a 100000 kHz clock and the full 200 us wait, so the precharge lands on cycle 20000. It sets precharge, mode-load and refresh times of 18, 12 and 61 ns. These give 1.8, 1.2 and 6.1 cycles, so each spacing only comes out right if the conversion rounds up to 2, 2 and 7. NUM_REFRESH is set to 9, one above the floor, so a counter that stops at eight is caught. Three full runs use two mode words, with one reset dropped in the middle of the refresh burst and one after done.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE_GAP,
    ST_MRD_GAP,
    ST_REF_GAP,
    ST_DONE
  } init_st_e;

  // ceil(t_ns * f_khz / 1e6), never below one cycle
  function automatic int ns_to_cyc(input longint t_ns, input longint f_khz);
    longint prod;
    longint cyc;
    prod = t_ns * f_khz;
    cyc  = (prod + 64'sd999999) / 64'sd1000000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_init_timer.sv
module sdr_init_timer #(
  parameter int                TMR_W   = 16,
  parameter logic [TMR_W-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
  import sdr_init_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int N_RP    = 2,
  parameter int N_MRD   = 2,
  parameter int N_RFC   = 7,
  parameter int REF_CNT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tmr_zero_i,
  output logic             load_o,
  output logic [TMR_W-1:0] load_val_o,
  output sdr_cmd_e         cmd_req_o,
  output logic             done_o
);

  localparam int               RC_W   = $clog2(REF_CNT + 1);
  localparam logic [TMR_W-1:0] RP_LD  = TMR_W'(N_RP - 1);
  localparam logic [TMR_W-1:0] MRD_LD = TMR_W'(N_MRD - 1);
  localparam logic [TMR_W-1:0] RFC_LD = TMR_W'(N_RFC - 1);
  localparam logic [RC_W-1:0]  REF_LAST = RC_W'(REF_CNT);

  init_st_e        st_q, st_d;
  logic [RC_W-1:0] ref_q;
  logic            ref_inc;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    cmd_req_o  = CMD_NOP;
    ref_inc    = 1'b0;
    unique case (st_q)
      ST_WAIT: if (tmr_zero_i) begin
        cmd_req_o  = CMD_PRE;
        load_o     = 1'b1;
        load_val_o = RP_LD;
        st_d       = ST_PRE_GAP;
      end
      ST_PRE_GAP: if (tmr_zero_i) begin
        cmd_req_o  = CMD_LMR;
        load_o     = 1'b1;
        load_val_o = MRD_LD;
        st_d       = ST_MRD_GAP;
      end
      ST_MRD_GAP: if (tmr_zero_i) begin
        cmd_req_o  = CMD_REF;
        load_o     = 1'b1;
        load_val_o = RFC_LD;
        ref_inc    = 1'b1;
        st_d       = ST_REF_GAP;
      end
      ST_REF_GAP: if (tmr_zero_i) begin
        if (ref_q == REF_LAST) begin
          st_d = ST_DONE;
        end else begin
          cmd_req_o  = CMD_REF;
          load_o     = 1'b1;
          load_val_o = RFC_LD;
          ref_inc    = 1'b1;
        end
      end
      ST_DONE: ;
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (ref_inc) ref_q <= ref_q + 1'b1;
    end
  end

  assign done_o = (st_q == ST_DONE);

endmodule

// File: rtl/sdr_init_cmd_drv.sv
module sdr_init_cmd_drv
  import sdr_init_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdr_cmd_e          cmd_req_i,
  input  logic [ROW_W-1:0]  mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [DQM_W-1:0]  dqm_o
);

  localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

  logic [3:0]        cmd_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BANK_W-1:0] ba_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
    end else begin
      cmd_q <= cmd_req_i;
      ba_q  <= '0;  // precharge-all and mode load both use bank 0
      unique case (cmd_req_i)
        CMD_PRE: addr_q <= AP_MASK;
        CMD_LMR: addr_q <= mode_i;
        default: addr_q <= '0;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign addr_o = addr_q;
  assign ba_o   = ba_q;
  // data pins stay high-Z through init
  assign cke_o  = 1'b1;
  assign dqm_o  = '1;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdr_init_pkg::*;
#(
  parameter int CLK_FREQ_KHZ = 100000,
  parameter int T_INIT_NS    = 200000,
  parameter int T_RP_NS      = 20,
  parameter int T_MRD_NS     = 15,
  parameter int T_RFC_NS     = 66,
  parameter int NUM_REFRESH  = 8,
  parameter int ROW_W        = 13,
  parameter int BANK_W       = 2,
  parameter int DQM_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  mode_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              init_done_o
);

  localparam int N_INIT  = ns_to_cyc(longint'(T_INIT_NS), longint'(CLK_FREQ_KHZ));
  localparam int N_RP    = ns_to_cyc(longint'(T_RP_NS),   longint'(CLK_FREQ_KHZ));
  localparam int N_MRD   = ns_to_cyc(longint'(T_MRD_NS),  longint'(CLK_FREQ_KHZ));
  localparam int N_RFC   = ns_to_cyc(longint'(T_RFC_NS),  longint'(CLK_FREQ_KHZ));
  localparam int REF_CNT = max_int(NUM_REFRESH, 8);
  localparam int MAX_LD  = max_int(max_int(N_INIT, N_RP), max_int(N_MRD, N_RFC));
  localparam int TMR_W   = $clog2(MAX_LD + 1);
  localparam logic [TMR_W-1:0] INIT_LD = TMR_W'(N_INIT - 1);

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  sdr_cmd_e         cmd_req;

  sdr_init_timer #(
    .TMR_W  (TMR_W),
    .RST_VAL(INIT_LD)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  sdr_init_fsm #(
    .TMR_W  (TMR_W),
    .N_RP   (N_RP),
    .N_MRD  (N_MRD),
    .N_RFC  (N_RFC),
    .REF_CNT(REF_CNT)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmr_zero_i(tmr_zero),
    .load_o    (tmr_load),
    .load_val_o(tmr_val),
    .cmd_req_o (cmd_req),
    .done_o    (init_done_o)
  );

  sdr_init_cmd_drv #(
    .ROW_W (ROW_W),
    .BANK_W(BANK_W),
    .DQM_W (DQM_W),
    .AP_BIT(10)
  ) u_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_req_i(cmd_req),
    .mode_i   (mode_i),
    .cke_o    (cke_o),
    .cs_n_o   (cs_n_o),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .we_n_o   (we_n_o),
    .addr_o   (addr_o),
    .ba_o     (ba_o),
    .dqm_o    (dqm_o)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int N_RP    = 2,
  parameter int N_MRD   = 2,
  parameter int N_RFC   = 7,
  parameter int REF_CNT = 8,
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cmd_i,
  input logic [ROW_W-1:0]  addr_i,
  input logic [BANK_W-1:0] ba_i,
  input logic [ROW_W-1:0]  mode_i,
  input logic              done_i
);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;

  logic [31:0] since_q;
  logic [3:0]  last_q;
  logic [31:0] refs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      last_q  <= C_NOP;
      refs_q  <= '0;
    end else if (cmd_i != C_NOP) begin
      since_q <= 32'd1;
      last_q  <= cmd_i;
      if (cmd_i == C_REF) refs_q <= refs_q + 32'd1;
    end else if (since_q != '1) begin
      since_q <= since_q + 32'd1;
    end
  end

  // R4
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_PRE) |-> (addr_i[10] && last_q == C_NOP && ba_i == '0));

  // R5
  lmr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_LMR) |-> (last_q == C_PRE && since_q >= 32'(N_RP)));

  // R5
  lmr_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_LMR) |-> (addr_i == $past(mode_i) && ba_i == '0));

  // R6
  ref_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_REF) |-> ((last_q == C_LMR && since_q >= 32'(N_MRD)) ||
                          (last_q == C_REF && since_q >= 32'(N_RFC))));

  // R6
  ref_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (refs_q == 32'(REF_CNT) && since_q >= 32'(N_RFC)));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);

  // R8
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (cmd_i == C_NOP));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .N_RP   (N_RP),
  .N_MRD  (N_MRD),
  .N_RFC  (N_RFC),
  .REF_CNT(REF_CNT),
  .ROW_W  (ROW_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cmd_i ({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
  .addr_i(addr_o),
  .ba_i  (ba_o),
  .mode_i(mode_i),
  .done_i(init_done_o)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;

  localparam int FREQ_KHZ = 100000;
  localparam int TI_NS    = 200000;
  localparam int TRP_NS   = 18;
  localparam int TMRD_NS  = 12;
  localparam int TRFC_NS  = 61;
  localparam int NREF     = 9;

  function automatic int up_cyc(input longint t, input longint f);
    longint c;
    c = (t * f + 64'sd999999) / 64'sd1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int E_INIT = up_cyc(TI_NS, FREQ_KHZ);   // 20000
  localparam int E_RP   = up_cyc(TRP_NS, FREQ_KHZ);  // 2
  localparam int E_MRD  = up_cyc(TMRD_NS, FREQ_KHZ); // 2
  localparam int E_RFC  = up_cyc(TRFC_NS, FREQ_KHZ); // 7
  localparam int NEV    = NREF + 2;

  localparam logic [12:0] MODE_A = 13'h0033;
  localparam logic [12:0] MODE_B = 13'h0227;
  localparam logic [12:0] USE_MODE = 13'h1FFF; // marker: expect mode word

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] gap;
    logic [12:0] addr;
  } ev_t;

  localparam ev_t EV_TAB [NEV] = '{
    '{4'b0010, 32'(E_INIT), 13'h0400},
    '{4'b0000, 32'(E_RP),   USE_MODE},
    '{4'b0001, 32'(E_MRD),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000},
    '{4'b0001, 32'(E_RFC),  13'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] mode = MODE_A;
  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [12:0] addr;
  logic [1:0]  ba, dqm;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int mask_viol = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(
    .CLK_FREQ_KHZ(FREQ_KHZ),
    .T_INIT_NS   (TI_NS),
    .T_RP_NS     (TRP_NS),
    .T_MRD_NS    (TMRD_NS),
    .T_RFC_NS    (TRFC_NS),
    .NUM_REFRESH (NREF)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .cke_o      (cke),
    .cs_n_o     (cs_n),
    .ras_n_o    (ras_n),
    .cas_n_o    (cas_n),
    .we_n_o     (we_n),
    .addr_o     (addr),
    .ba_o       (ba),
    .dqm_o      (dqm),
    .init_done_o(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // R3: masks and clock enable high whenever init is not done (and after)
  always @(negedge clk) begin
    if (cke !== 1'b1 || dqm !== 2'b11) mask_viol <= mask_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset presents NOP and clears done
    chk(cmd_now() == 4'b0111 && addr == 13'h0 && ba == 2'b00, "R1",
        "cmd/addr in reset", {cmd_now(), addr}, {4'b0111, 13'h0});
    chk(done == 1'b0, "R9", "done in reset", done, 0);
    chk(cke && dqm == 2'b11, "R3", "cke/dqm in reset", {cke, dqm}, 3'b111);
    rst_n = 1'b1;
  endtask

  task automatic full_run(input logic [12:0] mw);
    int prev;
    int quiet_bad;
    logic [12:0] ea;
    prev = 0;
    quiet_bad = 0;
    mode = mw;
    for (int i = 0; i < NEV; i++) begin
      int lim;
      lim = prev + int'(EV_TAB[i].gap) + 10;
      do begin
        @(negedge clk);
        if (cmd_now() == 4'b0111 && (addr != 13'h0 || ba != 2'b00 || done))
          quiet_bad++;
      end while (cmd_now() == 4'b0111 && cyc < lim);
      ea = (EV_TAB[i].addr == USE_MODE) ? mw : EV_TAB[i].addr;
      // R4 R5 R6: command order
      chk(cmd_now() == EV_TAB[i].cmd, (i == 0) ? "R4" : (i == 1) ? "R5" : "R6",
          $sformatf("cmd #%0d", i), cmd_now(), EV_TAB[i].cmd);
      // R2 R7: exact rounded-up spacing
      chk(cyc - prev == int'(EV_TAB[i].gap), (i == 0) ? "R2" : "R7",
          $sformatf("gap before #%0d", i), cyc - prev, int'(EV_TAB[i].gap));
      chk(addr == ea && ba == 2'b00, (i == 1) ? "R5" : "R4",
          $sformatf("addr/ba #%0d", i), {ba, addr}, {2'b00, ea});
      prev = cyc;
    end
    // R8: done timing after the last refresh
    while (!done && cyc < prev + E_RFC + 10) @(negedge clk);
    chk(done && (cyc - prev == E_RFC), "R8", "done delay", cyc - prev, E_RFC);
    // R6: no extra refresh after the expected count
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cmd_now() != 4'b0111 || !done) quiet_bad++;
    end
    chk(quiet_bad == 0, "R1", "idle cycles clean", quiet_bad, 0);
    chk(mask_viol == 0, "R3", "cke/dqm stayed high", mask_viol, 0);
  endtask

  initial begin
    #(300000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold_reset();
    full_run(MODE_A);

    // R9: reset in the middle of the refresh burst
    hold_reset();
    while (cyc < E_INIT + E_RP + E_MRD + 3 * E_RFC) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(cmd_now() == 4'b0111 && !done, "R9", "async clear mid-burst",
        {cmd_now(), done}, {4'b0111, 1'b0});
    hold_reset();
    full_run(MODE_B);

    // R9: reset after done clears it, then the whole sequence repeats
    hold_reset();
    @(negedge clk);
    chk(!done && cmd_now() == 4'b0111, "R9", "restart idle", {done, cmd_now()}, 4'b0111);
    full_run(MODE_A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule